// File: doc/BRIEF.md
# GPIO Output Data and Pin Readback Bank

This block keeps the output data state for a configurable number of general-purpose I/O lines and drives the pad output and output-enable vectors from that state. Software changes output bits in three ways: a set-bits write, a clear-bits write, or a direct write of the data word. A direct write is masked per line by a write-enable status that software controls. Each line also has a drive enable and an open-drain enable. With open-drain on, a data bit of 1 releases the pad and a data bit of 0 pulls it low.

A pin status word reports the real level on every pad, whichever agent drives it. The pad inputs pass through a two-stage synchronizer. The second stage is the readback register, so a stable pad level shows up after two clock edges. When the block clock enable is low, both stages hold, and readback keeps the levels it captured last. The register bus is a plain word-addressed port with one write strobe and combinational read data.

Top module: `gpio_out_bank`

## Requirements
- R1: After reset the output data, write-enable status, open-drain status and drive status all read 0, and pad_oe_o is all 0.
- R2: A write to address 0 (set) forces every line whose write-data bit is 1 to output 1. Lines written with 0 keep their value.
- R3: A write to address 1 (clear) forces every line whose write-data bit is 1 to output 0. Lines written with 0 keep their value.
- R4: A write to address 2 (data) loads the write-data bit only into lines whose write-enable status bit is 1. Every other line keeps its value. Address 2 reads back the output data.
- R5: Writing 1s to address 3 turns on those write-enable status bits, and writing 1s to address 4 turns them off. Bits written as 0 keep their value. Address 5 reads the status.
- R6: Addresses 6 and 7 turn open-drain bits on and off in the same way, and address 8 reads them. When a driven line has open-drain on and output data 1, its pad_oe_o bit is 0.
- R7: Addresses 9 and 10 turn drive bits on and off, and address 11 reads them. pad_oe_o[i] is the drive bit AND NOT (open-drain bit AND data bit). pad_o equals the output data.
- R8: Address 12 reads the pad level. The level on pad_i before a clock edge appears there after the second edge, and is not yet visible after the first.
- R9: While clk_en_i is 0, the pin status read at address 12 holds the level captured last. Once clk_en_i returns to 1, it follows pad_i again with the latency given in R8.
- R10: Addresses 0, 1, 3, 4, 6, 7, 9, 10 and 13 to 15 read as 0, and a write to an address from 13 to 15 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Block clock enable for pin sampling |
| addr_i | input | 4 | Register word address |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | DATA_W | Read data (combinational) |
| pad_i | input | NPINS | Pad input levels |
| pad_o | output | NPINS | Pad output values |
| pad_oe_o | output | NPINS | Pad output enables |

## Verification
The hardest case to reach is the readback hold. The pad levels have to change while sampling is stopped, and readback has to be checked several cycles later, before sampling resumes. The bench loops pad_o back onto pad_i through a model of the external pull level. It stops clk_en_i and moves the external levels, then checks the frozen readback. It then checks the two-edge catch-up cycle by cycle. The open-drain release is seen at the port in the same way: a line with output 1 reads whatever the external level is.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_SET      = 4'd0,
    A_CLR      = 4'd1,
    A_DATA     = 4'd2,
    A_WEN_ON   = 4'd3,
    A_WEN_OFF  = 4'd4,
    A_WEN_STAT = 4'd5,
    A_OD_ON    = 4'd6,
    A_OD_OFF   = 4'd7,
    A_OD_STAT  = 4'd8,
    A_DRV_ON   = 4'd9,
    A_DRV_OFF  = 4'd10,
    A_DRV_STAT = 4'd11,
    A_PIN_STAT = 4'd12
  } reg_addr_e;
endpackage

// File: rtl/gpio_ctl_bits.sv
module gpio_ctl_bits #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] on_i,
  input  logic [N-1:0] off_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] stat_q;

  // off wins on a same-cycle collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q | on_i) & ~off_i;
  end

  assign stat_o = stat_q;

  // R5 / R6 / R7 enable path
  p_on_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((on_i & ~off_i) != '0) |=> ((stat_o & $past(on_i & ~off_i)) == $past(on_i & ~off_i)));
  p_off_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_i != '0) |=> ((stat_o & $past(off_i)) == '0));
  p_idle_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_i == '0 && off_i == '0) |=> $stable(stat_o));
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         dir_we_i,
  input  logic [N-1:0] dir_val_i,
  input  logic [N-1:0] wen_i,
  output logic [N-1:0] data_o
);
  logic [N-1:0] data_q, dir_d, data_d;

  always_comb begin
    dir_d  = dir_we_i ? ((data_q & ~wen_i) | (dir_val_i & wen_i)) : data_q;
    data_d = (dir_d | set_i) & ~clr_i;   // clear has priority over set
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= data_d;
  end

  assign data_o = data_q;

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i & ~clr_i) != '0) |=> ((data_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));
  p_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((data_o & $past(clr_i)) == '0));
  p_masked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_we_i && set_i == '0 && clr_i == '0) |=> (((data_o ^ $past(data_o)) & ~$past(wen_i)) == '0));
endmodule

// File: rtl/gpio_pin_sample.sv
module gpio_pin_sample #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] pad_i,
  output logic [N-1:0] pin_o
);
  logic [N-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [N-1:0] src;
      if (s == 0) begin : g_first
        assign src = pad_i;
      end else begin : g_next
        assign src = stage_q[s-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   stage_q[s] <= '0;
        else if (en_i) stage_q[s] <= src;
      end
    end
  endgenerate

  assign pin_o = stage_q[STAGES-1];

  p_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(pin_o));
endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank
  import gpio_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NPINS-1:0]  pad_i,
  output logic [NPINS-1:0]  pad_o,
  output logic [NPINS-1:0]  pad_oe_o
);
  logic [NPINS-1:0] wd;
  logic [NPINS-1:0] set_v, clr_v;
  logic [NPINS-1:0] wen_on, wen_off, od_on, od_off, drv_on, drv_off;
  logic [NPINS-1:0] data_q, wen_q, od_q, drv_q, pin_q;
  logic             dir_we;

  assign wd = wdata_i[NPINS-1:0];

  generate
    if (DATA_W > NPINS) begin : g_unused
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata_i[DATA_W-1:NPINS];
    end
  endgenerate

  function automatic logic [NPINS-1:0] hit(input reg_addr_e a);
    return (we_i && addr_i == a) ? wd : '0;
  endfunction

  assign set_v   = hit(A_SET);
  assign clr_v   = hit(A_CLR);
  assign wen_on  = hit(A_WEN_ON);
  assign wen_off = hit(A_WEN_OFF);
  assign od_on   = hit(A_OD_ON);
  assign od_off  = hit(A_OD_OFF);
  assign drv_on  = hit(A_DRV_ON);
  assign drv_off = hit(A_DRV_OFF);
  assign dir_we  = we_i && (addr_i == A_DATA);

  gpio_out_latch #(.N(NPINS)) u_data (
    .clk_i, .rst_ni,
    .set_i(set_v), .clr_i(clr_v),
    .dir_we_i(dir_we), .dir_val_i(wd), .wen_i(wen_q),
    .data_o(data_q)
  );

  gpio_ctl_bits #(.N(NPINS)) u_wen (
    .clk_i, .rst_ni, .on_i(wen_on), .off_i(wen_off), .stat_o(wen_q)
  );

  gpio_ctl_bits #(.N(NPINS)) u_od (
    .clk_i, .rst_ni, .on_i(od_on), .off_i(od_off), .stat_o(od_q)
  );

  gpio_ctl_bits #(.N(NPINS)) u_drv (
    .clk_i, .rst_ni, .on_i(drv_on), .off_i(drv_off), .stat_o(drv_q)
  );

  gpio_pin_sample #(.N(NPINS), .STAGES(2)) u_pin (
    .clk_i, .rst_ni, .en_i(clk_en_i), .pad_i, .pin_o(pin_q)
  );

  // open-drain: a 1 releases the pad, a 0 pulls low
  assign pad_o    = data_q;
  assign pad_oe_o = drv_q & ~(od_q & data_q);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_DATA:     rdata_o[NPINS-1:0] = data_q;
      A_WEN_STAT: rdata_o[NPINS-1:0] = wen_q;
      A_OD_STAT:  rdata_o[NPINS-1:0] = od_q;
      A_DRV_STAT: rdata_o[NPINS-1:0] = drv_q;
      A_PIN_STAT: rdata_o[NPINS-1:0] = pin_q;
      default:    rdata_o = '0;
    endcase
  end

  p_od_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o & od_q & pad_o) == '0));
  p_undriven_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pad_oe_o & ~drv_q) == '0));
  p_reset_oe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pad_oe_o == '0));
endmodule

// File: tb/gpio_out_bank_test.sv
module gpio_out_bank_test;
  localparam int N  = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en = 1'b1;
  logic [3:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          we = 1'b0;
  logic [DW-1:0] rdata;
  logic [N-1:0]  pad_in, pad_out, pad_oe;
  logic [N-1:0]  ext = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [N-1:0] e_data = '0, e_wen = '0, e_od = '0, e_drv = '0;

  always #4ns clk = ~clk;

  // loopback: driven lines read back their own value, others see ext
  always_comb begin
    for (int i = 0; i < N; i++) pad_in[i] = pad_oe[i] ? pad_out[i] : ext[i];
  end

  gpio_out_bank #(.NPINS(N), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(clk_en),
    .addr_i(addr), .wdata_i(wdata), .we_i(we), .rdata_o(rdata),
    .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk);
    addr = a; wdata = DW'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [DW-1:0] d);
    addr = a;
    #1ns;
    d = rdata;
  endtask

  function automatic logic [N-1:0] oe_exp();
    return e_drv & ~(e_od & e_data);
  endfunction

  initial begin
    #(8ns * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd2, r);  chk("R1 data", r, '0);
    rd(4'd5, r);  chk("R1 wen", r, '0);
    rd(4'd8, r);  chk("R1 od", r, '0);
    rd(4'd11, r); chk("R1 drv", r, '0);
    chk("R1 pad_oe", DW'(pad_oe), '0);

    // R2 set sweep
    for (int p = 1; p < 256; p += 37) begin
      wr(4'd0, N'(p)); e_data |= N'(p);
      rd(4'd2, r); chk("R2 set", r, DW'(e_data));
      chk("R2 pad_o", DW'(pad_out), DW'(e_data));
    end
    // R3 clear sweep
    for (int p = 3; p < 256; p += 41) begin
      wr(4'd1, N'(p)); e_data &= ~N'(p);
      rd(4'd2, r); chk("R3 clr", r, DW'(e_data));
      wr(4'd0, N'(p ^ 8'h5A)); e_data |= N'(p ^ 8'h5A);
      rd(4'd2, r); chk("R3 reset-after-clr set", r, DW'(e_data));
    end

    // R4 / R5 masked direct write sweep
    for (int m = 0; m < 256; m += 51) begin
      wr(4'd4, 8'hFF); wr(4'd3, N'(m)); e_wen = N'(m);
      rd(4'd5, r); chk("R5 wen stat", r, DW'(e_wen));
      for (int v = 0; v < 256; v += 85) begin
        wr(4'd2, N'(v)); e_data = (e_data & ~e_wen) | (N'(v) & e_wen);
        rd(4'd2, r); chk("R4 direct", r, DW'(e_data));
      end
    end
    wr(4'd4, 8'h0F); e_wen &= ~8'h0F;
    rd(4'd5, r); chk("R5 wen off partial", r, DW'(e_wen));
    wr(4'd3, 8'hFF); e_wen = 8'hFF;

    // R7 drive enable
    wr(4'd9, 8'hF3); e_drv = 8'hF3;
    rd(4'd11, r); chk("R7 drv stat", r, DW'(e_drv));
    wr(4'd10, 8'h03); e_drv &= ~8'h03;
    rd(4'd11, r); chk("R7 drv off", r, DW'(e_drv));
    chk("R7 pad_oe", DW'(pad_oe), DW'(oe_exp()));

    // R6 open drain sweep over data
    wr(4'd6, 8'h3C); e_od = 8'h3C;
    wr(4'd7, 8'h0C); e_od &= ~8'h0C;
    rd(4'd8, r); chk("R6 od stat", r, DW'(e_od));
    wr(4'd9, 8'hFF); e_drv = 8'hFF;
    for (int v = 0; v < 256; v += 15) begin
      wr(4'd2, N'(v)); e_data = N'(v);
      chk("R6 pad_oe", DW'(pad_oe), DW'(oe_exp()));
      chk("R7 pad_o", DW'(pad_out), DW'(e_data));
    end

    // R8 latency: release all pads, move ext
    wr(4'd10, 8'hFF); e_drv = '0;
    ext = 8'h00;
    repeat (3) @(negedge clk);
    addr = 4'd12;
    ext = 8'hA5;
    @(posedge clk); #1ns;
    chk("R8 not after 1 edge", rdata, 32'h00);
    @(posedge clk); #1ns;
    chk("R8 after 2 edges", rdata, 32'hA5);
    // driven lines read own value, open-drain 1 reads ext
    wr(4'd2, 8'h0F); e_data = 8'h0F;
    wr(4'd6, 8'hFF); wr(4'd7, 8'hFE); e_od = 8'h01;
    wr(4'd9, 8'h0F); e_drv = 8'h0F;
    ext = 8'hF0;
    repeat (3) @(negedge clk);
    rd(4'd12, r);
    chk("R8 loopback", r, 32'hFE);
    ext = 8'hF1;
    repeat (3) @(negedge clk);
    rd(4'd12, r);
    chk("R6 released reads ext", r, 32'hFF);

    // R9 freeze
    clk_en = 1'b0;
    ext = 8'h00;
    wr(4'd10, 8'hFF); e_drv = '0;
    repeat (5) @(negedge clk);
    rd(4'd12, r);
    chk("R9 frozen", r, 32'hFF);
    clk_en = 1'b1;
    @(posedge clk); #1ns;
    chk("R9 resume edge 1", rdata, 32'hFF);
    @(posedge clk); #1ns;
    chk("R9 resume edge 2", rdata, 32'h00);

    // R10 write-only and unmapped reads, unmapped write
    @(negedge clk);
    for (int a = 0; a < 16; a++) begin
      if (a == 0 || a == 1 || a == 3 || a == 4 || a == 6 || a == 7 || a == 9 || a == 10 || a >= 13) begin
        rd(4'(a), r); chk("R10 reads zero", r, '0);
      end
    end
    for (int a = 13; a < 16; a++) wr(4'(a), 8'hFF);
    rd(4'd2, r);  chk("R10 data untouched", r, DW'(e_data));
    rd(4'd5, r);  chk("R10 wen untouched", r, DW'(e_wen));
    rd(4'd8, r);  chk("R10 od untouched", r, DW'(e_od));
    rd(4'd11, r); chk("R10 drv untouched", r, DW'(e_drv));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule